// File: doc/BRIEF.md
# Per-Slave Interrupt Status Aggregator

This block gathers interrupt events raised by the slaves on a serial management bus and presents them to a host processor. Each of up to sixteen slave IDs owns an 8-bit lane. Four slaves share one 32-bit status word, so the lanes fill four consecutive status words. An event arrives as a slave ID and an 8-bit pattern. The pattern is ORed into that slave's lane, and the bits stay set until software clears them.

Software reads and clears the lanes through a plain register port. Writing ones to a status word clears the matching bits. A 16-bit enable mask, one bit per slave, decides which slaves may drive the single level-sensitive interrupt line toward the host. A read-only summary word shows, with one bit per slave, which lanes hold any set bit, whether or not the slave is enabled.

The event input is a one-beat valid strobe with no ready signal, so the block accepts an event on every cycle and applies no back-pressure. Register reads are combinational on the address. Register writes take effect at the next rising clock edge.

Top module: `sirq_aggr`

## Requirements
- R1: After a synchronous active-low reset, all status lanes and the enable mask are zero, every register reads zero, and `irq_o` is low.
- R2: An accepted event (`evt_valid` high, `evt_sid` < 16) ORs `evt_bits` into the lane of slave n. Slave n appears in the status word at offset 0x20 + 4*(n/4), bits [(n%4)*8+7 : (n%4)*8]. Bits already set are kept.
- R3: A write to a status word clears each lane bit whose write-data bit is 1. Bits written with 0 are unchanged.
- R4: When an event sets a bit in the same cycle that a write clears that bit, the bit stays set.
- R5: Events with `evt_sid` of 16 or more change no lane.
- R6: The enable mask at offset 0x30 is read and written on data bits [15:0], where bit n belongs to slave n. Bits [31:16] read zero.
- R7: `irq_o` is high exactly when at least one slave has its enable bit set and a nonzero lane. A disabled slave still latches events.
- R8: The summary word at offset 0x34 has bit n set when lane n is nonzero, regardless of the enable mask. Writes to it have no effect.
- R9: Addresses other than 0x20, 0x24, 0x28, 0x2C, 0x30 and 0x34 read zero, and writes to them change nothing.
- R10: Writing 0xFFFFFFFF to all four status words empties every lane and drops `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_valid | input | 1 | Event strobe, accepted on every cycle it is high |
| evt_sid | input | 5 | Slave ID of the event |
| evt_bits | input | 8 | Bits to set in the slave's lane |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The bench builds the block with its default parameters: sixteen slaves, 8-bit lanes and a 5-bit slave ID. With these values every lane, every status word and all sixteen out-of-range IDs can be swept in full. Each slave gets accumulating patterns and then partial and full clears. The expected words, summary and interrupt level are computed from a lane model in the bench after every step, so each combination of the enable mask and lane contents that the sweeps reach is checked against the interrupt line.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int unsigned STAT_BASE = 32'h20;
  localparam int unsigned EN_OFS    = 32'h30;
  localparam int unsigned SUM_OFS   = 32'h34;
endpackage

// File: rtl/sirq_lane.sv
module sirq_lane #(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] set_i,
  input  logic [LANE_W-1:0] clr_i,
  output logic [LANE_W-1:0] lane_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) lane_o <= '0;
    else        lane_o <= (lane_o & ~clr_i) | set_i;  // set dominates clear
  end
endmodule

// File: rtl/sirq_regif.sv
module sirq_regif #(
  parameter int NUM_SLV = 16,
  parameter int LANE_W  = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic                      reg_we,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [DATA_W-1:0]         reg_wdata,
  input  logic [NUM_SLV*LANE_W-1:0] lane_flat,
  input  logic [NUM_SLV-1:0]        en_q,
  input  logic [NUM_SLV-1:0]        nz,
  output logic [DATA_W-1:0]         reg_rdata,
  output logic [NUM_SLV*LANE_W-1:0] clr_flat,
  output logic                      en_we
);
  import sirq_pkg::*;
  localparam int LPW     = DATA_W / LANE_W;
  localparam int NWORDS  = NUM_SLV / LPW;
  localparam int WIDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  logic [ADDR_W-1:0] off;
  logic              stat_hit;
  logic [WIDX_W-1:0] widx;

  assign off      = reg_addr - ADDR_W'(STAT_BASE);
  assign stat_hit = (reg_addr >= ADDR_W'(STAT_BASE)) &&
                    (off < ADDR_W'(4 * NWORDS)) && (off[1:0] == 2'b00);
  assign widx     = off[2 +: WIDX_W];
  assign en_we    = reg_we && (reg_addr == ADDR_W'(EN_OFS));

  for (genvar n = 0; n < NUM_SLV; n++) begin : g_clr
    assign clr_flat[n*LANE_W +: LANE_W] =
      (reg_we && stat_hit && (widx == WIDX_W'(n / LPW)))
        ? reg_wdata[(n % LPW)*LANE_W +: LANE_W] : '0;
  end

  always_comb begin
    reg_rdata = '0;
    if (stat_hit) begin
      for (int k = 0; k < NWORDS; k++)
        if (widx == WIDX_W'(k)) reg_rdata = lane_flat[k*DATA_W +: DATA_W];
    end else if (reg_addr == ADDR_W'(EN_OFS)) begin
      reg_rdata[NUM_SLV-1:0] = en_q;
    end else if (reg_addr == ADDR_W'(SUM_OFS)) begin
      reg_rdata[NUM_SLV-1:0] = nz;
    end
  end
endmodule

// File: rtl/sirq_aggr.sv
module sirq_aggr #(
  parameter int NUM_SLV = 16,
  parameter int LANE_W  = 8,
  parameter int SID_W   = 5,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [SID_W-1:0]  evt_sid,
  input  logic [LANE_W-1:0] evt_bits,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  logic [NUM_SLV*LANE_W-1:0] lane_flat;
  logic [NUM_SLV*LANE_W-1:0] clr_flat;
  logic [NUM_SLV-1:0]        en_q;
  logic [NUM_SLV-1:0]        nz;
  logic                      en_we;

  for (genvar n = 0; n < NUM_SLV; n++) begin : g_slv
    logic [LANE_W-1:0] set_n;
    assign set_n = (evt_valid && (evt_sid == SID_W'(n))) ? evt_bits : '0;
    sirq_lane #(.LANE_W(LANE_W)) lane_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_n),
      .clr_i  (clr_flat[n*LANE_W +: LANE_W]),
      .lane_o (lane_flat[n*LANE_W +: LANE_W])
    );
    assign nz[n] = |lane_flat[n*LANE_W +: LANE_W];
  end

  sirq_regif #(
    .NUM_SLV(NUM_SLV), .LANE_W(LANE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) regif_i (
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .lane_flat (lane_flat),
    .en_q      (en_q),
    .nz        (nz),
    .reg_rdata (reg_rdata),
    .clr_flat  (clr_flat),
    .en_we     (en_we)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= reg_wdata[NUM_SLV-1:0];
  end

  assign irq_o = |(en_q & nz);
endmodule

// File: rtl/sirq_aggr_chk.sv
module sirq_aggr_chk #(
  parameter int NUM_SLV = 16,
  parameter int LANE_W  = 8,
  parameter int SID_W   = 5,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      evt_valid,
  input logic [SID_W-1:0]          evt_sid,
  input logic [LANE_W-1:0]         evt_bits,
  input logic [ADDR_W-1:0]         reg_addr,
  input logic                      reg_we,
  input logic [DATA_W-1:0]         reg_wdata,
  input logic                      irq_o,
  input logic [NUM_SLV*LANE_W-1:0] lane_flat,
  input logic [NUM_SLV-1:0]        en_q
);
  logic              hit_q;
  logic [SID_W-1:0]  sid_q;
  logic [LANE_W-1:0] bits_q;
  logic [LANE_W-1:0] lane_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q <= 1'b0; sid_q <= '0; bits_q <= '0;
    end else begin
      hit_q  <= evt_valid && (int'(evt_sid) < NUM_SLV);
      sid_q  <= evt_sid;
      bits_q <= evt_bits;
    end
  end

  always_comb begin
    lane_sel = '0;
    for (int n = 0; n < NUM_SLV; n++)
      if (sid_q == SID_W'(n)) lane_sel = lane_flat[n*LANE_W +: LANE_W];
  end

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> ((lane_sel & bits_q) == bits_q));
  // R5
  bad_sid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && int'(evt_sid) >= NUM_SLV && !reg_we) |=> $stable(lane_flat));
  // R7
  irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_flat == '0) |-> !irq_o);
  // R7
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (en_q != '0));
  // R3
  word0_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(32'h20) && reg_wdata == '1 && !evt_valid)
      |=> (lane_flat[DATA_W-1:0] == '0));
endmodule

bind sirq_aggr sirq_aggr_chk #(
  .NUM_SLV(NUM_SLV), .LANE_W(LANE_W), .SID_W(SID_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_sid(evt_sid),
  .evt_bits(evt_bits), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .irq_o(irq_o), .lane_flat(lane_flat), .en_q(en_q)
);

// File: tb/sirq_aggr_tb_top.sv
module sirq_aggr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [4:0]  evt_sid = '0;
  logic [7:0]  evt_bits = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0]  mdl [16];
  logic [15:0] en_m = '0;

  always #2 clk = ~clk;

  sirq_aggr dut_i (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_sid(evt_sid),
    .evt_bits(evt_bits), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  function automatic logic [31:0] exp_word(int k);
    return {mdl[4*k+3], mdl[4*k+2], mdl[4*k+1], mdl[4*k]};
  endfunction
  function automatic logic [15:0] exp_sum();
    logic [15:0] s;
    for (int n = 0; n < 16; n++) s[n] = (mdl[n] != 0);
    return s;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    reg_addr = a;
    #1 chk(req, reg_rdata, exp);
  endtask

  task automatic all_chk(string req);
    for (int k = 0; k < 4; k++) rd(8'h20 + 8'(4*k), exp_word(k), req);
    rd(8'h34, {16'h0, exp_sum()}, req);
    chk(req, {31'h0, irq_o}, {31'h0, |(en_m & exp_sum())});
  endtask

  // one cycle carrying an optional event and an optional write
  task automatic cyc(logic ev, logic [4:0] sid, logic [7:0] bits,
                     logic we, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    evt_valid = ev; evt_sid = sid; evt_bits = bits;
    reg_we = we; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    evt_valid = 1'b0; reg_we = 1'b0;
    if (we && a >= 8'h20 && a <= 8'h2C && a[1:0] == 2'b00)
      for (int j = 0; j < 4; j++) mdl[(a - 8'h20)/4*4 + j] &= ~d[8*j +: 8];
    if (we && a == 8'h30) en_m = d[15:0];
    if (ev && sid < 16) mdl[sid] |= bits;
  endtask

  initial begin
    for (int n = 0; n < 16; n++) mdl[n] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    all_chk("R1");
    rd(8'h30, 32'h0, "R1");
    // R2 sweep: every slave, two accumulating patterns
    for (int n = 0; n < 16; n++) begin
      cyc(1'b1, 5'(n), 8'(1 << (n % 8)), 1'b0, 8'h0, 32'h0);
      rd(8'h20 + 8'(4*(n/4)), exp_word(n/4), "R2");
      cyc(1'b1, 5'(n), 8'h80 ^ 8'(n), 1'b0, 8'h0, 32'h0);
      rd(8'h20 + 8'(4*(n/4)), exp_word(n/4), "R2");
    end
    // R7 masked lanes latch but keep irq low; R8 summary before masking
    all_chk("R8");
    chk("R7", {31'h0, irq_o}, 32'h0);
    // R6 enable register
    cyc(1'b0, 5'h0, 8'h0, 1'b1, 8'h30, 32'hFFFF_A5A5);
    rd(8'h30, 32'h0000_A5A5, "R6");
    chk("R7", {31'h0, irq_o}, 32'h1);
    // R3 partial then full clear per slave, R7 level tracked
    for (int n = 0; n < 16; n++) begin
      cyc(1'b0, 5'h0, 8'h0, 1'b1, 8'h20 + 8'(4*(n/4)), 32'(8'h0F) << (8*(n%4)));
      all_chk("R3");
      cyc(1'b0, 5'h0, 8'h0, 1'b1, 8'h20 + 8'(4*(n/4)), 32'(8'hF0) << (8*(n%4)));
      all_chk("R7");
    end
    // R5 invalid IDs
    for (int s = 16; s < 32; s++) cyc(1'b1, 5'(s), 8'hFF, 1'b0, 8'h0, 32'h0);
    all_chk("R5");
    // R4 set and clear in one cycle
    cyc(1'b1, 5'd6, 8'hFF, 1'b0, 8'h0, 32'h0);
    cyc(1'b1, 5'd5, 8'h0F, 1'b1, 8'h24, 32'hFFFF_FFFF);
    all_chk("R4");
    rd(8'h24, 32'h0000_0F00, "R4");
    // R8 summary not writable; R9 unmapped addresses
    cyc(1'b0, 5'h0, 8'h0, 1'b1, 8'h34, 32'hFFFF_FFFF);
    all_chk("R8");
    cyc(1'b0, 5'h0, 8'h0, 1'b1, 8'h38, 32'hFFFF_FFFF);
    cyc(1'b0, 5'h0, 8'h0, 1'b1, 8'h22, 32'hFFFF_FFFF);
    cyc(1'b0, 5'h0, 8'h0, 1'b1, 8'h00, 32'hFFFF_FFFF);
    all_chk("R9");
    rd(8'h30, {16'h0, en_m}, "R9");
    rd(8'h38, 32'h0, "R9");
    rd(8'h1C, 32'h0, "R9");
    rd(8'hFC, 32'h0, "R9");
    // R10 fill all then clear all
    for (int n = 0; n < 16; n++) cyc(1'b1, 5'(n), 8'(8'h11 * (n % 15 + 1)), 1'b0, 8'h0, 32'h0);
    cyc(1'b0, 5'h0, 8'h0, 1'b1, 8'h30, 32'hFFFF);
    all_chk("R10");
    for (int k = 0; k < 4; k++) cyc(1'b0, 5'h0, 8'h0, 1'b1, 8'h20 + 8'(4*k), 32'hFFFF_FFFF);
    all_chk("R10");
    chk("R10", {31'h0, irq_o}, 32'h0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule